// File: doc/BRIEF.md
# Digit-Strobed Multiplexed Setting Decoder

This block recovers configuration settings that a board encodes by wiring a sense pin to one of the display's digit strobe lines. There are no dedicated mode pins. Four active-low sense lines are watched: function, range, control and external decimal point. The scan generator drives a one-hot digit strobe and a `slot_late` flag, which marks the second half of each digit slot. For every sense line the block notes which slots found the line asserted. When a full eight-slot scan is complete, it turns those slot masks into a function code, a range code, a set of control flags and a decimal-point digit mask.

The control line may be tied to several strobes at once, so several flags can be combined. The function and range lines carry a value only when exactly one slot asserts them. Any other pattern leaves the previous setting in place. A one-cycle pulse tells the measurement sequencer that the function or range setting has changed. While the display-off condition holds, the sense lines are not looked at. All pins are plain level signals. There is no handshake at the edge, because the settings are static levels that the consumer reads whenever it needs them.

Top module: `mux_sense_decoder`

## Requirements
- R1: Sense lines are active low. A line at 0 during a sampled cycle marks the current slot as asserted for that line. Slot Dn is strobe bit n-1, so D1 is bit 0 and D8 is bit 7.
- R2: A slot is sampled only when `slot_late` is 1 and the strobe is exactly one-hot. Sense levels in the first half of a slot, or under a strobe that is not one-hot, have no effect.
- R3: The function code comes from the single slot asserting the function line. D1 gives frequency (0), D8 gives period (1), D2 gives ratio (2), D5 gives time interval (3), D4 gives unit counter (4) and D3 gives oscillator self-test (5). The code never exceeds 5.
- R4: The range code comes from the single slot asserting the range line. D1 gives 0 (x1), D2 gives 1 (x10), D3 gives 2 (x100) and D4 gives 3 (x1000).
- R5: Each control flag is set when the control line is asserted in its slot. D8 sets display test, D2 sets 1 MHz select, D1 sets external oscillator and D3 sets external decimal point. Any combination may be active in one scan.
- R6: `disp_off` is high only while the stored D4 control flag and `hold` are both high. While `disp_off` is high, sampling stops and no decoded output changes.
- R7: `dp_digit` equals the slots that found the decimal-point line asserted, but only when the external decimal-point flag is set in the same scan. Otherwise it is all zero.
- R8: Outputs update only after a scan in which all eight slots were sampled. The update happens on the edge where the D8 sampling window is seen to end, so a partial scan changes nothing.
- R9: `setting_change` is high for exactly one cycle after an update in which the function or range code took a new value.
- R10: If no slot, or more than one slot, asserts the function line, the function code keeps its old value. The same holds for the range line, where a lone slot outside D1 to D4 also counts as no value.
- R11: After reset the function code is 0, the range code is 0, all flags are 0, `dp_digit` is 0 and `setting_change` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| digit_strobe | input | SLOTS | One-hot digit strobe; bit 0 is D1 |
| slot_late | input | 1 | High in the second half of the current slot |
| sense_func_n | input | 1 | Function sense line, active low |
| sense_range_n | input | 1 | Range sense line, active low |
| sense_ctrl_n | input | 1 | Control sense line, active low |
| sense_dp_n | input | 1 | Decimal-point sense line, active low |
| hold | input | 1 | Hold level, qualifies display off |
| func_code | output | 3 | Decoded function |
| range_code | output | 2 | Decoded range |
| disp_off | output | 1 | Display off (stored flag and hold) |
| disp_test | output | 1 | Display test flag |
| sel_1mhz | output | 1 | 1 MHz timebase select flag |
| ext_osc_en | output | 1 | External oscillator flag |
| ext_dp_en | output | 1 | External decimal point flag |
| dp_digit | output | SLOTS | Decimal-point digit mask |
| setting_change | output | 1 | One-cycle function/range change pulse |

## Verification
The scan end is detected in the first cycle after D8's late half in which the D8 window is no longer present. All decoded outputs and `setting_change` are registered on that edge, so they are due one cycle after the bench drives that idle cycle. `disp_off` is the only output that follows `hold` with no register, and it is due in the same cycle. The bench drives inputs on falling edges, adds exactly one idle cycle after each scan, and samples on the next falling edge. It then checks one cycle later that the pulse has dropped. Early halves of every slot carry the inverse of the late-half levels, so any sampling outside the window would corrupt the expected results.

// File: rtl/mux_sense_pkg.sv
`timescale 1ns/1ps
package mux_sense_pkg;
  localparam int NUM_SLOTS = 8;
  localparam int FUNC_W    = 3;
  localparam int RANGE_W   = 2;
  localparam int LINES     = 4;

  // slot indexes (bit position in the strobe)
  localparam int S_D1 = 0;
  localparam int S_D2 = 1;
  localparam int S_D3 = 2;
  localparam int S_D4 = 3;
  localparam int S_D5 = 4;
  localparam int S_D8 = 7;

  // sense line indexes
  localparam int L_FUNC  = 0;
  localparam int L_RANGE = 1;
  localparam int L_CTRL  = 2;
  localparam int L_DP    = 3;

  typedef enum logic [FUNC_W-1:0] {
    FN_FREQ     = 3'd0,
    FN_PERIOD   = 3'd1,
    FN_RATIO    = 3'd2,
    FN_INTERVAL = 3'd3,
    FN_UNIT     = 3'd4,
    FN_OSCTEST  = 3'd5
  } func_e;

  typedef struct packed {
    logic  ok;
    func_e code;
  } func_dec_t;

  typedef struct packed {
    logic               ok;
    logic [RANGE_W-1:0] code;
  } range_dec_t;

  function automatic logic only_slot(logic [NUM_SLOTS-1:0] m, int idx);
    return m == (NUM_SLOTS'(1) << idx);
  endfunction

  function automatic logic slot_bit(logic [NUM_SLOTS-1:0] m, int idx);
    return m[idx];
  endfunction

  function automatic func_dec_t decode_func(logic [NUM_SLOTS-1:0] m);
    func_dec_t r;
    r.ok   = 1'b1;
    r.code = FN_FREQ;
    if (only_slot(m, S_D1))      r.code = FN_FREQ;
    else if (only_slot(m, S_D8)) r.code = FN_PERIOD;
    else if (only_slot(m, S_D2)) r.code = FN_RATIO;
    else if (only_slot(m, S_D5)) r.code = FN_INTERVAL;
    else if (only_slot(m, S_D4)) r.code = FN_UNIT;
    else if (only_slot(m, S_D3)) r.code = FN_OSCTEST;
    else                         r.ok   = 1'b0;
    return r;
  endfunction

  function automatic range_dec_t decode_range(logic [NUM_SLOTS-1:0] m);
    range_dec_t r;
    r.ok   = 1'b0;
    r.code = '0;
    for (int i = 0; i < (1 << RANGE_W); i++) begin
      if (only_slot(m, S_D1 + i)) begin
        r.ok   = 1'b1;
        r.code = RANGE_W'(i);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/mux_scan_tracker.sv
`timescale 1ns/1ps
module mux_scan_tracker #(
  parameter int SLOTS = mux_sense_pkg::NUM_SLOTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] strobe,
  input  logic             slot_late,
  input  logic             freeze,
  output logic             sample_en,
  output logic             commit,
  output logic             clear
);
  localparam logic [SLOTS-1:0] ALL_SEEN = '1;

  logic             last_win;
  logic             last_win_q;
  logic             scan_end;
  logic [SLOTS-1:0] seen_q;

  assign last_win  = slot_late & strobe[SLOTS-1];
  assign scan_end  = last_win_q & ~last_win;
  assign sample_en = slot_late & $onehot(strobe) & ~freeze;
  assign commit    = scan_end & (seen_q == ALL_SEEN) & ~freeze;
  assign clear     = scan_end | freeze;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_win_q <= 1'b0;
      seen_q     <= '0;
    end else begin
      last_win_q <= last_win;
      if (clear)          seen_q <= '0;
      else if (sample_en) seen_q <= seen_q | strobe;
    end
  end
endmodule

// File: rtl/mux_sense_collector.sv
`timescale 1ns/1ps
module mux_sense_collector #(
  parameter int SLOTS = mux_sense_pkg::NUM_SLOTS,
  parameter int LINES = mux_sense_pkg::LINES
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        sample_en,
  input  logic [SLOTS-1:0]            strobe,
  input  logic [LINES-1:0]            sense_n,
  output logic [LINES-1:0][SLOTS-1:0] hits
);
  for (genvar l = 0; l < LINES; l++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hits[l] <= '0;
      else if (clear)     hits[l] <= '0;
      else if (sample_en) hits[l] <= hits[l] | (strobe & {SLOTS{~sense_n[l]}});
    end
  end
endmodule

// File: rtl/mux_setting_decoder.sv
`timescale 1ns/1ps
module mux_setting_decoder
  import mux_sense_pkg::*;
#(
  parameter int SLOTS = NUM_SLOTS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [SLOTS-1:0]   func_hits,
  input  logic [SLOTS-1:0]   range_hits,
  input  logic [SLOTS-1:0]   ctrl_hits,
  input  logic [SLOTS-1:0]   dp_hits,
  output func_e              func_q,
  output logic [RANGE_W-1:0] range_q,
  output logic               off_q,
  output logic               test_q,
  output logic               mhz_q,
  output logic               xosc_q,
  output logic               xdp_q,
  output logic [SLOTS-1:0]   dp_q,
  output logic               change_q
);
  func_dec_t  fdec;
  range_dec_t rdec;
  logic       new_xdp;
  logic       differs;

  assign fdec    = decode_func(func_hits);
  assign rdec    = decode_range(range_hits);
  assign new_xdp = slot_bit(ctrl_hits, S_D3);
  assign differs = (fdec.ok && fdec.code != func_q) || (rdec.ok && rdec.code != range_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q   <= FN_FREQ;
      range_q  <= '0;
      off_q    <= 1'b0;
      test_q   <= 1'b0;
      mhz_q    <= 1'b0;
      xosc_q   <= 1'b0;
      xdp_q    <= 1'b0;
      dp_q     <= '0;
      change_q <= 1'b0;
    end else begin
      change_q <= commit & differs;
      if (commit) begin
        if (fdec.ok) func_q  <= fdec.code;
        if (rdec.ok) range_q <= rdec.code;
        off_q  <= slot_bit(ctrl_hits, S_D4);
        test_q <= slot_bit(ctrl_hits, S_D8);
        mhz_q  <= slot_bit(ctrl_hits, S_D2);
        xosc_q <= slot_bit(ctrl_hits, S_D1);
        xdp_q  <= new_xdp;
        dp_q   <= new_xdp ? dp_hits : '0;
      end
    end
  end
endmodule

// File: rtl/mux_sense_decoder.sv
`timescale 1ns/1ps
module mux_sense_decoder
  import mux_sense_pkg::*;
#(
  parameter int SLOTS = NUM_SLOTS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SLOTS-1:0]   digit_strobe,
  input  logic               slot_late,
  input  logic               sense_func_n,
  input  logic               sense_range_n,
  input  logic               sense_ctrl_n,
  input  logic               sense_dp_n,
  input  logic               hold,
  output logic [FUNC_W-1:0]  func_code,
  output logic [RANGE_W-1:0] range_code,
  output logic               disp_off,
  output logic               disp_test,
  output logic               sel_1mhz,
  output logic               ext_osc_en,
  output logic               ext_dp_en,
  output logic [SLOTS-1:0]   dp_digit,
  output logic               setting_change
);
  logic                        sample_en;
  logic                        commit;
  logic                        clear;
  logic                        off_flag;
  logic [LINES-1:0]            sense_n;
  logic [LINES-1:0][SLOTS-1:0] hits;
  func_e                       func_q;

  assign sense_n[L_FUNC]  = sense_func_n;
  assign sense_n[L_RANGE] = sense_range_n;
  assign sense_n[L_CTRL]  = sense_ctrl_n;
  assign sense_n[L_DP]    = sense_dp_n;

  assign disp_off  = off_flag & hold;
  assign func_code = func_q;

  mux_scan_tracker #(.SLOTS(SLOTS)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (digit_strobe),
    .slot_late (slot_late),
    .freeze    (disp_off),
    .sample_en (sample_en),
    .commit    (commit),
    .clear     (clear)
  );

  mux_sense_collector #(.SLOTS(SLOTS), .LINES(LINES)) u_coll (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .sample_en (sample_en),
    .strobe    (digit_strobe),
    .sense_n   (sense_n),
    .hits      (hits)
  );

  mux_setting_decoder #(.SLOTS(SLOTS)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit),
    .func_hits  (hits[L_FUNC]),
    .range_hits (hits[L_RANGE]),
    .ctrl_hits  (hits[L_CTRL]),
    .dp_hits    (hits[L_DP]),
    .func_q     (func_q),
    .range_q    (range_code),
    .off_q      (off_flag),
    .test_q     (disp_test),
    .mhz_q      (sel_1mhz),
    .xosc_q     (ext_osc_en),
    .xdp_q      (ext_dp_en),
    .dp_q       (dp_digit),
    .change_q   (setting_change)
  );
endmodule

// File: rtl/mux_sense_checker.sv
`timescale 1ns/1ps
module mux_sense_checker #(
  parameter int SLOTS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SLOTS-1:0] digit_strobe,
  input logic             slot_late,
  input logic             hold,
  input logic [2:0]       func_code,
  input logic [1:0]       range_code,
  input logic             disp_off,
  input logic             setting_change
);
  logic d8_win;
  assign d8_win = slot_late && digit_strobe[SLOTS-1];

  // R3: only the six defined function codes appear
  p_func_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    func_code <= 3'd5);

  // R6: display off needs hold
  p_off_needs_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    disp_off |-> hold);

  // R6: nothing decoded moves while display is off
  p_frozen_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(disp_off) |-> ($stable(func_code) && $stable(range_code)));

  // R8: settings change only right after the D8 window has ended
  p_update_after_scan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(d8_win, 2) && !$past(d8_win)) |-> ($stable(func_code) && $stable(range_code)));

  // R9: pulse follows a scan end
  p_pulse_at_scan_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    setting_change |-> ($past(d8_win, 2) && !$past(d8_win)));

  // R9: pulse lasts one cycle
  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    setting_change |=> !setting_change);
endmodule

bind mux_sense_decoder mux_sense_checker #(.SLOTS(SLOTS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .digit_strobe   (digit_strobe),
  .slot_late      (slot_late),
  .hold           (hold),
  .func_code      (func_code),
  .range_code     (range_code),
  .disp_off       (disp_off),
  .setting_change (setting_change)
);

// File: tb/tb_mux_sense_decoder.sv
`timescale 1ns/1ps
module tb_mux_sense_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] strobe = '0;
  logic       late = 1'b0;
  logic       f_n = 1'b1, r_n = 1'b1, c_n = 1'b1, d_n = 1'b1;
  logic       hold = 1'b0;
  logic [2:0] func_code;
  logic [1:0] range_code;
  logic       disp_off, disp_test, sel_1mhz, ext_osc_en, ext_dp_en;
  logic [7:0] dp_digit;
  logic       setting_change;
  int         total = 0;
  int         bad = 0;

  always #5 clk = ~clk;

  mux_sense_decoder dut (
    .clk(clk), .rst_n(rst_n), .digit_strobe(strobe), .slot_late(late),
    .sense_func_n(f_n), .sense_range_n(r_n), .sense_ctrl_n(c_n), .sense_dp_n(d_n),
    .hold(hold), .func_code(func_code), .range_code(range_code),
    .disp_off(disp_off), .disp_test(disp_test), .sel_1mhz(sel_1mhz),
    .ext_osc_en(ext_osc_en), .ext_dp_en(ext_dp_en), .dp_digit(dp_digit),
    .setting_change(setting_change)
  );

  // vector: fmask rmask cmask dmask | func range flags{test,1mhz,xosc,xdp} dp chg
  localparam int NV = 9;
  localparam logic [49:0] TBL [NV] = '{
    {8'h80, 8'h04, 8'h00, 8'h00, 3'd1, 2'd2, 4'b0000, 8'h00, 1'b1},
    {8'h02, 8'h04, 8'h82, 8'h10, 3'd2, 2'd2, 4'b1100, 8'h00, 1'b1},
    {8'h02, 8'h04, 8'h05, 8'h10, 3'd2, 2'd2, 4'b0011, 8'h10, 1'b0},
    {8'h00, 8'h08, 8'h00, 8'h00, 3'd2, 2'd3, 4'b0000, 8'h00, 1'b1},
    {8'h11, 8'h30, 8'h04, 8'h03, 3'd2, 2'd3, 4'b0001, 8'h03, 1'b0},
    {8'h10, 8'h01, 8'h00, 8'h00, 3'd3, 2'd0, 4'b0000, 8'h00, 1'b1},
    {8'h08, 8'h02, 8'h00, 8'h00, 3'd4, 2'd1, 4'b0000, 8'h00, 1'b1},
    {8'h04, 8'h02, 8'h00, 8'h00, 3'd5, 2'd1, 4'b0000, 8'h00, 1'b1},
    {8'h01, 8'h02, 8'h00, 8'h00, 3'd0, 2'd1, 4'b0000, 8'h00, 1'b1}
  };

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(logic [7:0] s, logic l, logic [3:0] sn);
    @(negedge clk);
    strobe = s;
    late   = l;
    {d_n, c_n, r_n, f_n} = sn;
  endtask

  // early half drives the inverse of the late-half level (R2 stimulus)
  task automatic run_scan(logic [7:0] fm, logic [7:0] rm, logic [7:0] cm,
                          logic [7:0] dm, int first, bit glitch);
    if (glitch) repeat (2) drive(8'h03, 1'b1, 4'b0000);
    for (int i = first; i < 8; i++) begin
      logic [3:0] v;
      v = {dm[i], cm[i], rm[i], fm[i]};
      repeat (2) drive(8'(1 << i), 1'b0, v);
      repeat (2) drive(8'(1 << i), 1'b1, ~v);
    end
    drive(8'h00, 1'b0, 4'hf);
    @(negedge clk);
  endtask

  task automatic check_all(string tag, int ef, int er, int efl, int edp, int ech);
    check({tag, " R3 R10 func"}, func_code, ef);
    check({tag, " R4 R10 range"}, range_code, er);
    check({tag, " R5 flags"}, {disp_test, sel_1mhz, ext_osc_en, ext_dp_en}, efl);
    check({tag, " R7 dp"}, dp_digit, edp);
    check({tag, " R9 pulse"}, setting_change, ech);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check_all("R11 reset", 0, 0, 0, 0, 0);
    check("R11 reset disp_off", disp_off, 0);

    // R8: partial scan starting at D3 must not update
    run_scan(8'h80, 8'h08, 8'h02, 8'h00, 2, 1'b0);
    check_all("R8 partial", 0, 0, 0, 0, 0);

    // R1 R2 main table
    for (int k = 0; k < NV; k++) begin
      logic [49:0] v;
      v = TBL[k];
      run_scan(v[49:42], v[41:34], v[33:26], v[25:18], 0, 1'b0);
      check_all($sformatf("R1 R2 vec%0d", k), v[17:15], v[14:13], v[12:9], v[8:1], v[0]);
      @(negedge clk);
      check("R9 pulse single", setting_change, 0);
    end

    // R2: non-one-hot strobe with all lines asserted is ignored
    run_scan(8'h02, 8'h04, 8'h00, 8'h00, 0, 1'b1);
    check_all("R2 glitch", 2, 2, 0, 0, 1);

    // R6: display off flag with hold low stays inactive
    run_scan(8'h02, 8'h04, 8'h08, 8'h00, 0, 1'b0);
    check_all("R6 flag", 2, 2, 0, 0, 0);
    check("R6 off without hold", disp_off, 0);
    @(negedge clk);
    hold = 1'b1;
    @(negedge clk);
    check("R6 off with hold", disp_off, 1);
    run_scan(8'h80, 8'h01, 8'h00, 8'h00, 0, 1'b0);
    check_all("R6 frozen", 2, 2, 0, 0, 0);
    check("R6 still off", disp_off, 1);
    @(negedge clk);
    hold = 1'b0;
    run_scan(8'h80, 8'h01, 8'h00, 8'h00, 0, 1'b0);
    check_all("R6 resumed", 1, 0, 0, 0, 1);
    @(negedge clk);
    hold = 1'b1;
    @(negedge clk);
    check("R6 flag cleared", disp_off, 0);
    hold = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule